// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It handles a small integer subset: register-to-register add, subtract, AND, OR and signed set-on-less-than; OR with an immediate; word load and word store; branch-if-equal; and an absolute jump. Inside it are a 32-entry register file with two read ports and one write port, an immediate extender, an ALU, a program counter and a control section.

Decoding happens in two levels. The main decoder looks only at the 6-bit opcode. It produces the datapath steering bits and a 2-bit ALU operation class. A small local decoder then combines that class with the 6-bit function field of register-format instructions to form the 3-bit ALU control. This keeps the function field out of the main decoder.

Instruction and data memories connect through plain ports with a combinational read and a write on the rising clock edge, so a bench can model them as arrays. The core has no streaming interface. Each access completes in the cycle that issues it, so there is no valid/ready handshake and no back-pressure: the memories must answer in the same cycle.

Top module: `rcore_top`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 after the first clock edge and `dmem_we` is 0. The register file clears to zero, and execution starts at address 0 on the first edge after release.
- R2: After any instruction that is not a branch or a jump, the next fetch address is the current address plus 4.
- R3: Branch-if-equal has opcode 000100 and format op[31:26], rs[25:21], rt[20:16], imm[15:0]. If R[rs] equals R[rt], the next address is current+4+(sign-extended imm shifted left by 2). Otherwise it is current+4. It writes no register and no memory.
- R4: Jump has opcode 000010. The next address is {bits 31..28 of current+4, target[25:0], 00}. It writes no register and no memory.
- R5: Register-format instructions have opcode 000000 and fields rd[15:11] and funct[5:0]. They write R[rd] with R[rs] op R[rt], where funct selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-on-less-than (result 1 or 0).
- R6: OR-immediate has opcode 001101. It writes R[rt] with R[rs] OR the zero-extended imm.
- R7: Load word has opcode 100011. It drives `dmem_addr` with R[rs]+sign-extended imm and writes R[rt] with `dmem_rdata`.
- R8: Store word has opcode 101011. It is the only instruction that raises `dmem_we`. It drives `dmem_addr` with R[rs]+sign-extended imm and `dmem_wdata` with R[rt].
- R9: Register 0 reads as zero, and every write to it is dropped.
- R10: Any other opcode changes neither the registers nor memory, and the next address is current+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address from the ALU |
| dmem_wdata | output | 32 | Store data (R[rt]) |
| dmem_we | output | 1 | Data memory write strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
Register contents are visible only through later stores. A wrong register value, such as a bad ALU result, a bad extension or a write to register 0, therefore shows up as wrong `dmem_wdata` or `dmem_addr` at the next store or load that uses that register. That can be many cycles after the faulty write. The bench tracks which instruction class last wrote each register, so it can name the cause. A decode or next-address fault shows up on `imem_addr` one cycle after the offending instruction. A spurious memory write shows up on `dmem_we` in the same cycle.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  typedef enum logic [OP_W-1:0] {
    OP_RTYPE = 6'b000000,
    OP_JMP   = 6'b000010,
    OP_BEQ   = 6'b000100,
    OP_ORI   = 6'b001101,
    OP_LW    = 6'b100011,
    OP_SW    = 6'b101011
  } opcode_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 6'b100000,
    FN_SUB = 6'b100010,
    FN_AND = 6'b100100,
    FN_OR  = 6'b100101,
    FN_SLT = 6'b101010
  } funct_e;

  typedef enum logic [1:0] {
    AC_ADD   = 2'b00,
    AC_SUB   = 2'b01,
    AC_FUNCT = 2'b10,
    AC_OR    = 2'b11
  } alu_class_e;

  typedef enum logic [2:0] {
    AL_AND = 3'b000,
    AL_OR  = 3'b001,
    AL_ADD = 3'b010,
    AL_SUB = 3'b110,
    AL_SLT = 3'b111
  } alu_ctl_e;

  typedef struct packed {
    logic       reg_we;
    logic       dst_rd;
    logic       b_imm;
    logic       ext_sign;
    logic       mem_we;
    logic       mem_to_reg;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/rcore_main_dec.sv
module rcore_main_dec
  import rcore_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_class = AC_ADD;
    case (op)
      OP_RTYPE: begin
        ctrl.reg_we    = 1'b1;
        ctrl.dst_rd    = 1'b1;
        ctrl.alu_class = AC_FUNCT;
      end
      OP_ORI: begin
        ctrl.reg_we    = 1'b1;
        ctrl.b_imm     = 1'b1;
        ctrl.alu_class = AC_OR;
      end
      OP_LW: begin
        ctrl.reg_we     = 1'b1;
        ctrl.b_imm      = 1'b1;
        ctrl.ext_sign   = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we   = 1'b1;
        ctrl.b_imm    = 1'b1;
        ctrl.ext_sign = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch    = 1'b1;
        ctrl.ext_sign  = 1'b1;
        ctrl.alu_class = AC_SUB;
      end
      OP_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/rcore_alu_dec.sv
module rcore_alu_dec
  import rcore_pkg::*;
(
  input  alu_class_e      alu_class,
  input  logic [FN_W-1:0] funct,
  output alu_ctl_e        alu_ctl
);
  always_comb begin
    case (alu_class)
      AC_ADD: alu_ctl = AL_ADD;
      AC_SUB: alu_ctl = AL_SUB;
      AC_OR:  alu_ctl = AL_OR;
      default: begin
        case (funct)
          FN_ADD:  alu_ctl = AL_ADD;
          FN_SUB:  alu_ctl = AL_SUB;
          FN_AND:  alu_ctl = AL_AND;
          FN_OR:   alu_ctl = AL_OR;
          FN_SLT:  alu_ctl = AL_SLT;
          default: alu_ctl = AL_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W    = 32,
  parameter int N    = 32,
  localparam int AW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  ra_d,
  input  logic [AW-1:0] rb_a,
  output logic [W-1:0]  rb_d,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (we && (wa == AW'(i)) && (i != 0)) begin
        regs[i] <= wd;
      end
    end
  end

  assign ra_d = (ra_a == '0) ? '0 : regs[ra_a];
  assign rb_d = (rb_a == '0) ? '0 : regs[rb_a];
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_ctl_e     ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;

  assign diff = a - b;

  always_comb begin
    case (ctl)
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      AL_ADD:  y = a + b;
      AL_SUB:  y = diff;
      AL_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int EXT_W = XLEN - IMM_W;
  localparam int BR_W  = XLEN - IMM_W - 2;
  localparam int PCH_W = XLEN - TGT_W - 2;

  logic [XLEN-1:0]   pc_q, pc_plus4, next_pc, br_tgt, jmp_tgt;
  logic [OP_W-1:0]   op;
  logic [RIDX_W-1:0] rs_a, rt_a, rd_a, wr_a;
  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  tgt;
  logic [XLEN-1:0]   rs_d, rt_d, ext_imm, alu_b, alu_y, wb_d;
  logic              alu_zero, rf_we, take_br;
  ctrl_t             ctrl;
  alu_ctl_e          alu_ctl;

  assign op   = imem_rdata[31:26];
  assign rs_a = imem_rdata[25:21];
  assign rt_a = imem_rdata[20:16];
  assign rd_a = imem_rdata[15:11];
  assign imm  = imem_rdata[IMM_W-1:0];
  assign tgt  = imem_rdata[TGT_W-1:0];

  rcore_main_dec u_main (
    .op   (op),
    .ctrl (ctrl)
  );

  rcore_alu_dec u_aluc (
    .alu_class (ctrl.alu_class),
    .funct     (imm[FN_W-1:0]),
    .alu_ctl   (alu_ctl)
  );

  assign ext_imm = ctrl.ext_sign ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
  assign alu_b   = ctrl.b_imm ? ext_imm : rt_d;

  rcore_alu #(.W(XLEN)) u_alu (
    .ctl  (alu_ctl),
    .a    (rs_d),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wr_a  = ctrl.dst_rd ? rd_a : rt_a;
  assign wb_d  = ctrl.mem_to_reg ? dmem_rdata : alu_y;
  assign rf_we = ctrl.reg_we & rst_n;

  rcore_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_a  (rs_a),
    .ra_d  (rs_d),
    .rb_a  (rt_a),
    .rb_d  (rt_d),
    .we    (rf_we),
    .wa    (wr_a),
    .wd    (wb_d)
  );

  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {{BR_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1 -: PCH_W], tgt, 2'b00};
  assign take_br  = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)   next_pc = jmp_tgt;
    else if (take_br) next_pc = br_tgt;
    else              next_pc = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= next_pc;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_d;
  assign dmem_we    = ctrl.mem_we & rst_n;
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk
  import rcore_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_rdata,
  input logic            dmem_we,
  input logic            rf_we,
  input logic [4:0]      rs_a,
  input logic [XLEN-1:0] rs_d
);
  logic [5:0] op;
  logic       seq_op, known_op;

  assign op       = imem_rdata[31:26];
  assign seq_op   = (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) || (op == OP_SW);
  assign known_op = seq_op || (op == OP_BEQ) || (op == OP_JMP);

  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> (imem_addr == '0));

  a_r1_no_write_in_reset: assert property (@(posedge clk) !rst_n |-> !dmem_we);

  a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    seq_op |=> (imem_addr == $past(imem_addr) + 32'd4));

  a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JMP) |=> (imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}));

  a_r8_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (op == OP_SW));

  a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_a == 5'd0) |-> (rs_d == '0));

  a_r10_unknown_noop: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> (!dmem_we && !rf_we));

  a_r10_unknown_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |=> (imem_addr == $past(imem_addr) + 32'd4));
endmodule

bind rcore_top rcore_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .rf_we      (rf_we),
  .rs_a       (rs_a),
  .rs_d       (rs_d)
);

// File: tb/sim_rcore_top.sv
`timescale 1ns/1ps
module sim_rcore_top;
  import rcore_pkg::*;

  localparam int NSTEP = 3000;

  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem  [256];
  logic [31:0] dmem  [256];
  logic [31:0] mdmem [256];
  logic [31:0] mreg  [32];
  string       wtag  [32];
  logic [31:0] mpc;
  string       pc_tag;
  int          checks = 0;
  int          fails  = 0;
  int          pk     = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  rcore_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] t);
    return {6'b000010, t};
  endfunction

  task automatic put(input logic [31:0] ins);
    imem[pk] = ins;
    pk++;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] v, input string t);
    if (idx != 5'd0) begin
      mreg[idx] = v;
      wtag[idx] = t;
    end
  endtask

  // reference execution of one instruction, built from the requirements
  task automatic exec(input logic [31:0] ins);
    logic [5:0]  op;
    logic [4:0]  rs, rt, rd;
    logic [31:0] a, b, sx, zx, p4, ea, res;
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a  = mreg[rs]; b = mreg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0000, ins[15:0]};
    p4 = mpc + 32'd4;
    mpc = p4;
    pc_tag = "R2";
    case (op)
      6'b000000: begin
        case (ins[5:0])
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          default:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        wr(rd, res, "R5");
      end
      6'b001101: wr(rt, a | zx, "R6");
      6'b100011: begin ea = a + sx; wr(rt, mdmem[ea[9:2]], "R7"); end
      6'b101011: begin ea = a + sx; mdmem[ea[9:2]] = b; end
      6'b000100: begin pc_tag = "R3"; if (a == b) mpc = p4 + {sx[29:0], 2'b00}; end
      6'b000010: begin pc_tag = "R4"; mpc = {p4[31:28], ins[25:0], 2'b00}; end
      default:   pc_tag = "R10";
    endcase
  endtask

  function automatic logic [31:0] rand_instr();
    int          kind;
    logic [5:0]  op, fn;
    logic [15:0] off;
    int          rs, rt, rd;
    kind = int'($urandom % 16);
    rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
    case ($urandom % 5)
      0: fn = FN_ADD;
      1: fn = FN_SUB;
      2: fn = FN_AND;
      3: fn = FN_OR;
      default: fn = FN_SLT;
    endcase
    if (kind < 4 || kind == 15) return enc_r(fn, rd, rs, rt);
    if (kind < 6)  return enc_i(OP_ORI, rs, rt, 16'($urandom));
    if (kind < 8)  return enc_i(OP_LW, rs, rt, 16'($urandom));
    if (kind < 11) return enc_i(OP_SW, rs, rt, 16'($urandom));
    if (kind < 13) begin
      off = 16'(int'($urandom % 13) - 6);
      if (off == 16'hFFFF) off = 16'h0002;
      return enc_i(OP_BEQ, rs, rt, off);
    end
    if (kind == 13) return enc_j(26'($urandom % 256));
    op = 6'($urandom);
    if (op == 6'b000000 || op == 6'b000010 || op == 6'b000100 ||
        op == 6'b001101 || op == 6'b100011 || op == 6'b101011) op = 6'b111111;
    return {op, 26'($urandom)};
  endfunction

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] ins, v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      v = $urandom;
      dmem[i] = v;
      mdmem[i] = v;
    end
    for (int i = 0; i < 32; i++) begin
      mreg[i] = '0;
      wtag[i] = "R1";
    end
    wtag[0] = "R9";

    // directed corner cases
    put(enc_i(OP_ORI, 0, 1, 16'hFFFF));   // R6: zero extension, r1 = 0000FFFF
    put(enc_i(OP_ORI, 0, 2, 16'h8000));   // r2 = 00008000
    put(enc_r(FN_SUB, 3, 0, 1));          // R5: r3 negative
    put(enc_r(FN_SLT, 4, 3, 1));          // R5: signed slt -> 1
    put(enc_r(FN_SLT, 5, 1, 3));          // -> 0
    put(enc_r(FN_AND, 7, 1, 3));
    put(enc_r(FN_OR, 8, 2, 3));
    put(enc_r(FN_ADD, 0, 1, 1));          // R9: write to r0 dropped
    put(enc_i(OP_ORI, 0, 0, 16'h1234));   // R9
    put(enc_i(OP_SW, 0, 0, 16'h0000));    // R9: stores 0
    put(enc_i(OP_SW, 2, 1, 16'hFFFC));    // R8: negative offset
    put(enc_i(OP_LW, 2, 6, 16'hFFFC));    // R7
    put(enc_i(OP_SW, 0, 6, 16'h0004));
    put(enc_i(OP_SW, 0, 3, 16'h0008));
    put(enc_i(OP_SW, 0, 4, 16'h000C));
    put(enc_i(OP_SW, 0, 5, 16'h0010));
    put(enc_i(OP_SW, 0, 7, 16'h0014));
    put(enc_i(OP_SW, 0, 8, 16'h0018));
    put(enc_i(OP_BEQ, 1, 6, 16'h0001));   // R3: taken
    put(enc_i(OP_ORI, 0, 1, 16'h0000));   // skipped
    put(enc_i(OP_BEQ, 1, 0, 16'h0001));   // R3: not taken
    put({6'b111111, 5'd0, 5'd1, 16'h5555}); // R10: unknown opcode
    put(enc_i(OP_SW, 0, 1, 16'h001C));    // r1 unchanged
    put(enc_j(26'(pk + 2)));              // R4
    put(enc_i(OP_ORI, 0, 1, 16'h0000));   // skipped
    while (pk < 256) put(rand_instr());

    // R1: reset state
    @(negedge clk);
    chk("R1", "dmem_we in reset", {31'd0, dmem_we}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'd0);
    chk("R1", "dmem_we in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    mpc = 32'd0;
    pc_tag = "R1";
    #1;

    for (int s = 0; s < NSTEP; s++) begin
      chk(pc_tag, "fetch address", imem_addr, mpc);
      ins = imem[mpc[9:2]];
      if (ins[31:26] == 6'b101011) begin
        v = mreg[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
        chk("R8", "store strobe", {31'd0, dmem_we}, 32'd1);
        chk("R8", "store address", dmem_addr, v);
        chk({wtag[ins[20:16]], "/R8"}, "store data", dmem_wdata, mreg[ins[20:16]]);
      end else begin
        chk((ins[31:26] == 6'b000000 || ins[31:26] == 6'b000010 || ins[31:26] == 6'b000100 ||
             ins[31:26] == 6'b001101 || ins[31:26] == 6'b100011) ? "R8" : "R10",
            "no store strobe", {31'd0, dmem_we}, 32'd0);
        if (ins[31:26] == 6'b100011) begin
          v = mreg[ins[25:21]] + {{16{ins[15]}}, ins[15:0]};
          chk({wtag[ins[25:21]], "/R7"}, "load address", dmem_addr, v);
        end
      end
      exec(ins);
      @(negedge clk);
      #0.5;
    end
    report();
  end
endmodule